// File: doc/BRIEF.md
# Register-Programmed Watchdog with Selectable Expiry Action

This block is a watchdog peripheral on a simple register bus. Software loads a tick count into a timer register. While an expiry action is selected, the block decrements that count once per clock. Any write to the timer register reloads the count, and this write is the keepalive. When the count reaches zero, the block performs the selected action one time. The action is one of four: nothing, a level interrupt, a level non-maskable interrupt, or a one-cycle request for a full chip reset.

The control register also holds a read-only flag that records whether the last reset came from the watchdog. Only the power-on reset clears this flag. The ordinary system reset does not clear it, and that reset is the one the reset controller asserts in answer to the chip-reset request. Boot software can therefore read the flag after a restart to learn why the chip restarted. With the action field at zero the count does not move. Software can therefore load the timer first and enable an action afterwards, and the countdown starts from the newly loaded value.

Top module: `wdt_top`

## Requirements
- R1: After power-on reset, the control register (byte offset 0x0) and the timer register (byte offset 0x4) both read 0, and irq_o, nmi_o and chip_rst_o are low.
- R2: A control write stores only data bits [1:0] as the action field, with encoding 0 none, 1 interrupt, 2 non-maskable interrupt, 3 chip reset. Bit 31 is a read-only flag and ignores writes. A control read returns the flag in bit 31, the action in bits [1:0], and zero in all other bits.
- R3: A read request returns its data on rdata_o on the clock edge after the request. A timer read returns the live count as it was at the edge where the request is sampled.
- R4: While the action field is 0, the timer count holds its value.
- R5: While the action field is non-zero, the count falls by one on every clock and stays at zero once it reaches zero.
- R6: A timer write reloads the count with the written value and restarts the countdown, so repeated reloads keep the action from firing.
- R7: With action 1, irq_o rises on the clock edge after the edge at which the count becomes zero. irq_o then stays high until the timer is rewritten or the action field reads 0.
- R8: With action 2, nmi_o behaves the same way as irq_o does in R7.
- R9: With action 3, chip_rst_o is high for exactly one cycle on the edge after the count becomes zero, and it does not pulse again while the count stays at zero.
- R10: The last-reset flag (control bit 31) is set after a chip-reset request. The system reset rst_ni does not clear it, and the power-on reset por_ni does clear it.
- R11: No more than one of irq_o, nmi_o and chip_rst_o is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; the countdown advances by one tick per cycle |
| rst_ni | input | 1 | Active-low asynchronous system reset; does not clear the last-reset flag |
| por_ni | input | 1 | Active-low asynchronous power-on reset; clears everything, including the flag |
| req_i | input | 1 | Bus access strobe for the current cycle |
| we_i | input | 1 | 1 for a write, 0 for a read |
| addr_i | input | ADDR_W (4) | Byte address: 0x0 control, 0x4 timer |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data, valid one cycle after a read request |
| irq_o | output | 1 | Level interrupt on expiry with action 1 |
| nmi_o | output | 1 | Level non-maskable interrupt on expiry with action 2 |
| chip_rst_o | output | 1 | One-cycle chip-reset request on expiry with action 3 |

## Verification
The countdown is exercised four ways. A load made with no action set must hold its value, which separates "count only when armed" from free-running. Back-to-back live reads after an action is enabled pin down the exact cycle in which decrementing starts. A keepalive reload issued partway through a countdown must push expiry out by the full reload value, which separates reload from a one-time load. Each of the three firing actions then runs to expiry, and the bench checks the output level one cycle before and one cycle after the predicted edge. The bench also checks that each output clears on a reload or on setting the action to 0, and that the reset request is a single pulse. Last, the bench applies the system reset and then the power-on reset, which shows that only power-on clears the last-reset flag.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {
    ACT_NONE  = 2'd0,
    ACT_IRQ   = 2'd1,
    ACT_NMI   = 2'd2,
    ACT_RESET = 2'd3
  } wdt_action_e;

  localparam int unsigned CTRL_OFF  = 32'h0;
  localparam int unsigned TIMER_OFF = 32'h4;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] count_i,
  input  logic              flag_i,
  output logic [DATA_W-1:0] rdata_o,
  output wdt_action_e       act_o,
  output logic              load_o,
  output logic [DATA_W-1:0] load_val_o
);
  localparam logic [ADDR_W-1:0] CtrlAddr  = ADDR_W'(CTRL_OFF);
  localparam logic [ADDR_W-1:0] TimerAddr = ADDR_W'(TIMER_OFF);
  localparam int unsigned       PadW      = DATA_W - 3;

  wdt_action_e       act_q;
  logic [DATA_W-1:0] rdata_q;
  logic              ctrl_sel, timer_sel, rd;

  assign ctrl_sel  = req_i && (addr_i == CtrlAddr);
  assign timer_sel = req_i && (addr_i == TimerAddr);
  assign rd        = req_i && !we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    act_q <= ACT_NONE;
    else if (ctrl_sel && we_i)      act_q <= wdt_action_e'(wdata_i[1:0]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          rdata_q <= '0;
    else if (rd) begin
      if (ctrl_sel)       rdata_q <= {flag_i, {PadW{1'b0}}, act_q};
      else if (timer_sel) rdata_q <= count_i;
      else                rdata_q <= '0;
    end
  end

  assign rdata_o    = rdata_q;
  assign act_o      = act_q;
  assign load_o     = timer_sel && we_i;
  assign load_val_o = wdata_i;

  // R2: reserved control bits always read back as zero
  a_r2_ctrl_pad_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && ctrl_sel) |=> (rdata_o[DATA_W-2:2] == '0));
  // R3: a read of an unmapped address returns zero one cycle later
  a_r3_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && !ctrl_sel && !timer_sel) |=> (rdata_o == '0));
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             run_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (load_i)               cnt_q <= load_val_i;
    else if (run_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);

  // R4: an unarmed count stays put
  a_r4_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !run_i) |=> $stable(cnt_o));
  // R5: an armed count steps down by exactly one
  a_r5_step_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && run_i && !zero_o) |=> (cnt_o == $past(cnt_o) - 1'b1));
  // R5: zero is sticky without a reload
  a_r5_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && zero_o) |=> zero_o);
endmodule

// File: rtl/wdt_dispatch.sv
module wdt_dispatch
  import wdt_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        por_ni,
  input  wdt_action_e act_i,
  input  logic        zero_i,
  input  logic        load_i,
  output logic        irq_o,
  output logic        nmi_o,
  output logic        rst_req_o,
  output logic        flag_o
);
  logic fired_q, irq_q, nmi_q, rst_req_q, flag_q;
  logic disarm, fire;

  assign disarm = load_i || (act_i == ACT_NONE);
  assign fire   = !disarm && zero_i && !fired_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fired_q   <= 1'b0;
      irq_q     <= 1'b0;
      nmi_q     <= 1'b0;
      rst_req_q <= 1'b0;
    end else begin
      rst_req_q <= fire && (act_i == ACT_RESET);
      if (disarm) begin
        fired_q <= 1'b0;
        irq_q   <= 1'b0;
        nmi_q   <= 1'b0;
      end else if (fire) begin
        fired_q <= 1'b1;
        irq_q   <= (act_i == ACT_IRQ);
        nmi_q   <= (act_i == ACT_NMI);
      end
    end
  end

  // cleared by power-on only, so it outlives the reset it requested
  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni)        flag_q <= 1'b0;
    else if (rst_req_q) flag_q <= 1'b1;
  end

  assign irq_o     = irq_q;
  assign nmi_o     = nmi_q;
  assign rst_req_o = rst_req_q;
  assign flag_o    = flag_q;

  // R9: reset request is a single-cycle pulse
  a_r9_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o);
  // R10: flag set after a request
  a_r10_flag_set: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    rst_req_o |=> flag_o);
  // R10: flag never drops without power-on reset
  a_r10_flag_sticky: assert property (@(posedge clk_i) disable iff (!por_ni)
    flag_o |=> flag_o);
  // R11: outputs mutually exclusive
  a_r11_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({irq_o, nmi_o, rst_req_o}));
  // R7: interrupt only rises when the count is zero
  a_r7_irq_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(zero_i));
endmodule

// File: rtl/wdt_top.sv
module wdt_top
  import wdt_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              por_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              irq_o,
  output logic              nmi_o,
  output logic              chip_rst_o
);
  localparam int unsigned DataW = 32;

  logic              sys_rst_n;
  wdt_action_e       act;
  logic              load, zero, flag;
  logic [DataW-1:0]  load_val, cnt;

  assign sys_rst_n = rst_ni && por_ni;

  wdt_regs #(.ADDR_W(ADDR_W), .DATA_W(DataW)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (sys_rst_n),
    .req_i      (req_i),
    .we_i       (we_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .count_i    (cnt),
    .flag_i     (flag),
    .rdata_o    (rdata_o),
    .act_o      (act),
    .load_o     (load),
    .load_val_o (load_val)
  );

  wdt_countdown #(.CNT_W(DataW)) u_count (
    .clk_i      (clk_i),
    .rst_ni     (sys_rst_n),
    .load_i     (load),
    .load_val_i (load_val),
    .run_i      (act != ACT_NONE),
    .cnt_o      (cnt),
    .zero_o     (zero)
  );

  wdt_dispatch u_disp (
    .clk_i     (clk_i),
    .rst_ni    (sys_rst_n),
    .por_ni    (por_ni),
    .act_i     (act),
    .zero_i    (zero),
    .load_i    (load),
    .irq_o     (irq_o),
    .nmi_o     (nmi_o),
    .rst_req_o (chip_rst_o),
    .flag_o    (flag)
  );
endmodule

// File: tb/wdt_top_bench.sv
module wdt_top_bench;
  localparam int unsigned CLK_PERIOD = 10;
  localparam logic [3:0]  A_CTRL  = 4'h0;
  localparam logic [3:0]  A_TIMER = 4'h4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0, por_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, nmi, crst;

  int unsigned n_checks = 0, n_fail = 0;
  logic        done = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdt_top u_wdt_top (
    .clk_i(clk), .rst_ni(rst_n), .por_ni(por_n), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .irq_o(irq), .nmi_o(nmi), .chip_rst_o(crst)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  // driver: push expectation, issue read
  task automatic rd(logic [3:0] a, logic [31:0] exp, string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    req = 1'b0;
  endtask

  // monitor: response is valid after the edge following the request
  always @(posedge clk) rd_seen <= req && !we;
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, rdata, e);
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog timeout actual=running expected=done");
    finish_run();
  end

  initial begin
    cyc(3);
    por_n = 1'b1; rst_n = 1'b1;
    cyc(1);
    // R1 reset state
    check("R1 irq", {31'b0, irq}, 32'd0);
    check("R1 nmi", {31'b0, nmi}, 32'd0);
    check("R1 chip_rst", {31'b0, crst}, 32'd0);
    rd(A_CTRL, 32'h0, "R1 ctrl");
    rd(A_TIMER, 32'h0, "R1 timer");
    rd(4'h8, 32'h0, "R3 unmapped");

    // R4 load while disarmed holds
    wr(A_TIMER, 32'd1000);
    rd(A_TIMER, 32'd1000, "R4 hold a");
    cyc(5);
    rd(A_TIMER, 32'd1000, "R4 hold b");

    // R2 only bits [1:0] stored, bit31 read-only
    wr(A_CTRL, 32'hFFFF_FFFC);
    rd(A_CTRL, 32'h0, "R2 ctrl masked");
    wr(A_CTRL, 32'h8000_0002);
    // R3/R5 live count, decrement begins the edge after arming
    rd(A_TIMER, 32'd1000, "R3 live first");
    rd(A_TIMER, 32'd999, "R5 step");
    wr(A_CTRL, 32'h0);
    rd(A_TIMER, 32'd997, "R4 stop at disarm");
    rd(A_CTRL, 32'h0, "R2 ctrl zero");

    // R6/R7 keepalive, then irq expiry
    wr(A_CTRL, 32'h1);
    rd(A_CTRL, 32'h1, "R2 ctrl irq");
    wr(A_TIMER, 32'd5);
    cyc(3);
    wr(A_TIMER, 32'd5);
    cyc(4);
    check("R6 no fire after reload", {31'b0, irq}, 32'd0);
    cyc(1);
    check("R7 irq before edge", {31'b0, irq}, 32'd0);
    cyc(1);
    check("R7 irq asserted", {31'b0, irq}, 32'd1);
    check("R11 nmi low", {31'b0, nmi}, 32'd0);
    check("R11 chip_rst low", {31'b0, crst}, 32'd0);
    cyc(10);
    check("R7 irq level", {31'b0, irq}, 32'd1);
    rd(A_TIMER, 32'd0, "R5 floor");
    wr(A_TIMER, 32'd20);
    check("R7 irq clear on reload", {31'b0, irq}, 32'd0);
    wr(A_TIMER, 32'd0);
    cyc(1);
    check("R7 irq refire", {31'b0, irq}, 32'd1);
    wr(A_CTRL, 32'h0);
    cyc(1);
    check("R7 irq clear on disarm", {31'b0, irq}, 32'd0);

    // R8 nmi
    wr(A_TIMER, 32'd3);
    wr(A_CTRL, 32'h2);
    cyc(3);
    check("R8 nmi before edge", {31'b0, nmi}, 32'd0);
    cyc(1);
    check("R8 nmi asserted", {31'b0, nmi}, 32'd1);
    check("R11 irq low", {31'b0, irq}, 32'd0);
    wr(A_TIMER, 32'd50);
    check("R8 nmi clear on reload", {31'b0, nmi}, 32'd0);
    wr(A_CTRL, 32'h0);

    // R9 chip reset pulse, R10 flag
    wr(A_TIMER, 32'd4);
    wr(A_CTRL, 32'h3);
    cyc(4);
    check("R9 rst before edge", {31'b0, crst}, 32'd0);
    cyc(1);
    check("R9 rst pulse", {31'b0, crst}, 32'd1);
    check("R11 irq low in rst", {31'b0, irq}, 32'd0);
    cyc(1);
    check("R9 rst one cycle", {31'b0, crst}, 32'd0);
    cyc(5);
    check("R9 no refire", {31'b0, crst}, 32'd0);
    rd(A_CTRL, 32'h8000_0003, "R10 flag set");
    rst_n = 1'b0;
    cyc(2);
    rst_n = 1'b1;
    cyc(1);
    rd(A_CTRL, 32'h8000_0000, "R10 flag survives rst_ni");
    rd(A_TIMER, 32'h0, "R10 timer cleared by rst_ni");
    wr(A_CTRL, 32'h8000_0000);
    rd(A_CTRL, 32'h8000_0000, "R10 flag ignores write");
    por_n = 1'b0;
    cyc(2);
    por_n = 1'b1;
    cyc(1);
    rd(A_CTRL, 32'h0, "R10 flag cleared by por_ni");
    cyc(2);
    finish_run();
  end
endmodule